// File: doc/BRIEF.md
# Flash-Boot Configuration Supervisor

This block supervises a target FPGA that loads its own bitstream from an SPI serial flash, with the target acting as bus master. When asked to start, it first checks whether the target already reports a finished configuration. If the caller did not insist on a reload, it answers at once without touching the target. Otherwise it parks its own SPI drivers in high impedance, pulses the target's reset, and releases the target with its mode pins set to master-SPI boot.

The block waits a fixed settling time and then polls the target's DONE line once per tick, up to a tick budget. It also watches the flash chip-select. If that line stays idle (high) for a run of consecutive ticks, the target is judged to have given up and polling stops early. A successful boot yields result 0 and a one-cycle post-configuration pulse. A failed boot switches the mode pins away from master-SPI, holds reset low for one tick, and yields result 4. On exit the configuration pins go back to high impedance, the caller's SPI output enables pass through again, and the local chip-select is held high.

All waits are counted in ticks of an internal prescaler. The prescaler restarts when a boot begins, so every result arrives a known number of clock cycles after the start pulse.

Top module: `flash_boot_supervisor`

## Requirements
- R1: When `start` is sampled with `forceCfg`=0 and `targetDone`=1, `resultCode`=1 appears with `resultValid` in the very next cycle, and `cfgOe` stays 0 throughout.
- R2: While `busy` is 1, `spiOe` is all zeros. While `busy` is 0, `spiOe` equals `spiOeReq`.
- R3: A boot drives `cfgOe`=1, `targetResetN`=0 and `modeSel`=2'b00 for one tick, then `targetResetN`=1 with `modeSel`=2'b00. The encoding 2'b00 selects master-SPI boot.
- R4: After the reset tick, the block waits SETTLE_TICKS ticks. It then samples `targetDone` at each tick, for at most POLL_LIMIT+1 samples.
- R5: The block counts consecutive poll ticks with `flashCsIn`=1 and clears the count on a tick with `flashCsIn`=0. Once the count equals IDLE_LIMIT at a poll tick, polling ends as a failure.
- R6: If `targetDone`=1 at poll tick p (counting from 1), `resultCode`=0 and `postPulse`=1 appear together with `resultValid`, (1+SETTLE_TICKS+p)·TICK_DIV cycles after the start edge. `postPulse` is never 1 otherwise.
- R7: On failure at poll tick p, the block drives `modeSel`=2'b11 and `targetResetN`=0 for one tick, then reports `resultCode`=4, (2+SETTLE_TICKS+p)·TICK_DIV cycles after the start edge.
- R8: `cfgOe` is 0 in the `resultValid` cycle and whenever the block is idle. After any completion, `spiCsOut` is 1 until `spiCsReq` is seen at 1 while idle; after that, `spiCsOut` follows `spiCsReq`.
- R9: A tick occurs every TICK_DIV clock cycles. The prescaler restarts at the start edge, so the first tick is TICK_DIV cycles later.
- R10: After reset, `busy`, `resultValid`, `postPulse` and `cfgOe` are 0. `busy` is 1 from the start edge through the single `resultValid` cycle, and 0 right after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a supervision run (sampled when idle) |
| forceCfg | input | 1 | Reload even if the target is already configured |
| targetDone | input | 1 | Target configuration-done line |
| flashCsIn | input | 1 | Observed flash chip-select (1 = idle) |
| spiOeReq | input | SPI_OE_W | SPI output enables requested by surrounding logic |
| spiCsReq | input | 1 | Local chip-select value requested by surrounding logic |
| cfgOe | output | 1 | Drive enable for reset and mode pins (0 = high impedance) |
| targetResetN | output | 1 | Target reset value |
| modeSel | output | 2 | Target mode pins: 00 master-SPI boot, 11 leave boot mode |
| spiOe | output | SPI_OE_W | Effective local SPI output enables |
| spiCsOut | output | 1 | Effective local chip-select value |
| busy | output | 1 | Run in progress |
| resultValid | output | 1 | One-cycle strobe marking `resultCode` |
| resultCode | output | 3 | 0 success, 1 already configured, 4 error |
| postPulse | output | 1 | One-cycle post-configuration strobe on success |

## Verification
Every result has a fixed latency. It is 0 cycles after the start edge for the already-configured case, (1+S+p)·D for success, and (2+S+p)·D for failure, where p is the deciding poll tick. The bench counts clock edges from the start edge and compares the count at which `resultValid` is first seen with a software model of the polling loop. It changes `targetDone` and `flashCsIn` only half a cycle away from edges, and it sets their values as a function of the tick index that the next edge belongs to. The pin values in the cycle before the result tell success and failure apart, because they show what the block drove in its last tick.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESET,
    ST_SETTLE,
    ST_POLL,
    ST_LEAVE,
    ST_FIN
  } fbsState_t;

  typedef struct packed {
    logic tickClr;
    logic loadOne;
    logic loadSettle;
    logic pollClr;
    logic pollStep;
    logic finish;
  } fbsCtl_t;

  localparam logic [2:0] RES_OK      = 3'd0;
  localparam logic [2:0] RES_ALREADY = 3'd1;
  localparam logic [2:0] RES_ERROR   = 3'd4;

endpackage

// File: rtl/fbs_datapath.sv
module fbs_datapath
  import fbs_pkg::*;
#(
  parameter int TICK_DIV     = 100000,
  parameter int SETTLE_TICKS = 50,
  parameter int POLL_LIMIT   = 10000,
  parameter int IDLE_LIMIT   = 250,
  parameter int SPI_OE_W     = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  fbsCtl_t             ctl,
  input  logic                busy,
  input  logic                flashCsIn,
  input  logic [SPI_OE_W-1:0] spiOeReq,
  input  logic                spiCsReq,
  output logic                tick,
  output logic                waitLast,
  output logic                pollExhausted,
  output logic                idleFull,
  output logic [SPI_OE_W-1:0] spiOe,
  output logic                spiCsOut
);

  localparam int PRE_W  = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam int WAIT_W = $clog2(SETTLE_TICKS + 2);
  localparam int POLL_W = $clog2(POLL_LIMIT + 2);
  localparam int IDLE_W = $clog2(IDLE_LIMIT + 2);
  localparam logic [PRE_W-1:0]  PRE_MAX   = PRE_W'(TICK_DIV - 1);
  localparam logic [WAIT_W-1:0] SETTLE_LD = WAIT_W'(SETTLE_TICKS);
  localparam logic [POLL_W-1:0] POLL_END  = POLL_W'(POLL_LIMIT);
  localparam logic [IDLE_W-1:0] IDLE_END  = IDLE_W'(IDLE_LIMIT);

  logic [PRE_W-1:0]  preCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic [POLL_W-1:0] pollCnt;
  logic [IDLE_W-1:0] idleCnt;
  logic              csHold;

  // tick prescaler, restarted by the control at the start edge
  always_ff @(posedge clk) begin
    if (!rstN || ctl.tickClr || preCnt == PRE_MAX) preCnt <= '0;
    else                                           preCnt <= preCnt + 1'b1;
  end
  assign tick = (preCnt == PRE_MAX);

  // tick-based wait counter
  always_ff @(posedge clk) begin
    if (!rstN)                       waitCnt <= '0;
    else if (ctl.loadOne)            waitCnt <= WAIT_W'(1);
    else if (ctl.loadSettle)         waitCnt <= SETTLE_LD;
    else if (tick && waitCnt != '0)  waitCnt <= waitCnt - 1'b1;
  end
  assign waitLast = (waitCnt == WAIT_W'(1));

  // poll budget and idle chip-select run
  always_ff @(posedge clk) begin
    if (!rstN || ctl.pollClr) begin
      pollCnt <= '0;
      idleCnt <= '0;
    end else if (ctl.pollStep) begin
      pollCnt <= pollCnt + 1'b1;
      idleCnt <= flashCsIn ? idleCnt + 1'b1 : '0;
    end
  end
  assign pollExhausted = (pollCnt == POLL_END);
  assign idleFull      = (idleCnt == IDLE_END);

  // local SPI drivers
  always_ff @(posedge clk) begin
    if (!rstN)                  csHold <= 1'b0;
    else if (ctl.finish)        csHold <= 1'b1;
    else if (!busy && spiCsReq) csHold <= 1'b0;
  end
  assign spiOe    = busy ? '0 : spiOeReq;
  assign spiCsOut = busy | csHold | spiCsReq;

endmodule

// File: rtl/fbs_control.sv
module fbs_control
  import fbs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       forceCfg,
  input  logic       targetDone,
  input  logic       tick,
  input  logic       waitLast,
  input  logic       pollExhausted,
  input  logic       idleFull,
  output fbsCtl_t    ctl,
  output logic       busy,
  output logic       cfgOe,
  output logic       targetResetN,
  output logic [1:0] modeSel,
  output logic       resultValid,
  output logic [2:0] resultCode,
  output logic       postPulse
);

  fbsState_t  state, nxt;
  logic [2:0] codeReg, nxtCode;
  logic       postFlag, nxtPost;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      codeReg  <= RES_OK;
      postFlag <= 1'b0;
    end else begin
      state    <= nxt;
      codeReg  <= nxtCode;
      postFlag <= nxtPost;
    end
  end

  always_comb begin
    ctl     = '0;
    nxt     = state;
    nxtCode = codeReg;
    nxtPost = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        if (!forceCfg && targetDone) begin
          nxtCode = RES_ALREADY;
          nxt     = ST_FIN;
        end else begin
          ctl.tickClr = 1'b1;
          ctl.loadOne = 1'b1;
          nxt         = ST_RESET;
        end
      end
      ST_RESET: if (tick && waitLast) begin
        ctl.loadSettle = 1'b1;
        nxt            = ST_SETTLE;
      end
      ST_SETTLE: if (tick && waitLast) begin
        ctl.pollClr = 1'b1;
        nxt         = ST_POLL;
      end
      ST_POLL: if (tick) begin
        if (targetDone) begin
          nxtCode = RES_OK;
          nxtPost = 1'b1;
          nxt     = ST_FIN;
        end else if (pollExhausted || idleFull) begin
          ctl.loadOne = 1'b1;
          nxt         = ST_LEAVE;
        end else begin
          ctl.pollStep = 1'b1;
        end
      end
      ST_LEAVE: if (tick && waitLast) begin
        nxtCode = RES_ERROR;
        nxt     = ST_FIN;
      end
      ST_FIN: begin
        ctl.finish = 1'b1;
        nxt        = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign busy         = (state != ST_IDLE);
  assign resultValid  = (state == ST_FIN);
  assign resultCode   = codeReg;
  assign postPulse    = postFlag;
  assign cfgOe        = (state == ST_RESET) || (state == ST_SETTLE) ||
                        (state == ST_POLL)  || (state == ST_LEAVE);
  assign targetResetN = !((state == ST_RESET) || (state == ST_LEAVE));
  assign modeSel      = (state == ST_LEAVE) ? 2'b11 : 2'b00;

endmodule

// File: rtl/flash_boot_supervisor.sv
module flash_boot_supervisor
  import fbs_pkg::*;
#(
  parameter int TICK_DIV     = 100000,
  parameter int SETTLE_TICKS = 50,
  parameter int POLL_LIMIT   = 10000,
  parameter int IDLE_LIMIT   = 250,
  parameter int SPI_OE_W     = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                forceCfg,
  input  logic                targetDone,
  input  logic                flashCsIn,
  input  logic [SPI_OE_W-1:0] spiOeReq,
  input  logic                spiCsReq,
  output logic                cfgOe,
  output logic                targetResetN,
  output logic [1:0]          modeSel,
  output logic [SPI_OE_W-1:0] spiOe,
  output logic                spiCsOut,
  output logic                busy,
  output logic                resultValid,
  output logic [2:0]          resultCode,
  output logic                postPulse
);

  fbsCtl_t ctl;
  logic    tick, waitLast, pollExhausted, idleFull;

  fbs_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .forceCfg(forceCfg),
    .targetDone(targetDone), .tick(tick), .waitLast(waitLast),
    .pollExhausted(pollExhausted), .idleFull(idleFull), .ctl(ctl),
    .busy(busy), .cfgOe(cfgOe), .targetResetN(targetResetN),
    .modeSel(modeSel), .resultValid(resultValid),
    .resultCode(resultCode), .postPulse(postPulse)
  );

  fbs_datapath #(
    .TICK_DIV(TICK_DIV), .SETTLE_TICKS(SETTLE_TICKS),
    .POLL_LIMIT(POLL_LIMIT), .IDLE_LIMIT(IDLE_LIMIT), .SPI_OE_W(SPI_OE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busy(busy), .flashCsIn(flashCsIn),
    .spiOeReq(spiOeReq), .spiCsReq(spiCsReq), .tick(tick),
    .waitLast(waitLast), .pollExhausted(pollExhausted),
    .idleFull(idleFull), .spiOe(spiOe), .spiCsOut(spiCsOut)
  );

endmodule

// File: rtl/fbs_checker.sv
module fbs_checker #(
  parameter int SPI_OE_W = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                busy,
  input logic                resultValid,
  input logic [2:0]          resultCode,
  input logic                postPulse,
  input logic                cfgOe,
  input logic [SPI_OE_W-1:0] spiOe
);

  // R2
  spi_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> spiOe == '0);

  // R6
  post_with_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    postPulse |-> (resultValid && resultCode == 3'd0));

  // R8
  cfg_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgOe |-> busy);

  // R10
  valid_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> (!busy && !resultValid));

  // R10
  code_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (resultCode == 3'd0 || resultCode == 3'd1 || resultCode == 3'd4));

endmodule

bind flash_boot_supervisor fbs_checker #(.SPI_OE_W(SPI_OE_W)) u_fbsChk (
  .clk(clk), .rstN(rstN), .busy(busy), .resultValid(resultValid),
  .resultCode(resultCode), .postPulse(postPulse), .cfgOe(cfgOe),
  .spiOe(spiOe)
);

// File: tb/flash_boot_supervisor_test.sv
module flash_boot_supervisor_test;

  localparam int D    = 3;
  localparam int S    = 4;
  localparam int PL   = 30;
  localparam int IL   = 6;
  localparam int NVEC = 9;
  localparam int NEVER = 999;

  // {force, donePoll(10), csMode(2), expCode(3)}; donePoll 0 = high from before start
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b0, 10'd0,   2'd0, 3'd1},
    {1'b1, 10'd0,   2'd0, 3'd0},
    {1'b0, 10'd5,   2'd0, 3'd0},
    {1'b1, 10'd12,  2'd2, 3'd0},
    {1'b0, 10'd999, 2'd0, 3'd4},
    {1'b0, 10'd999, 2'd1, 3'd4},
    {1'b0, 10'd999, 2'd3, 3'd4},
    {1'b0, 10'd999, 2'd2, 3'd4},
    {1'b1, 10'd40,  2'd0, 3'd4}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0, forceCfg = 1'b0, targetDone = 1'b0, flashCsIn = 1'b1;
  logic [2:0] spiOeReq = 3'b000;
  logic       spiCsReq = 1'b0;
  logic       cfgOe, targetResetN, spiCsOut, busy, resultValid, postPulse;
  logic [1:0] modeSel;
  logic [2:0] spiOe, resultCode;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  flash_boot_supervisor #(
    .TICK_DIV(D), .SETTLE_TICKS(S), .POLL_LIMIT(PL), .IDLE_LIMIT(IL), .SPI_OE_W(3)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .forceCfg(forceCfg),
    .targetDone(targetDone), .flashCsIn(flashCsIn), .spiOeReq(spiOeReq),
    .spiCsReq(spiCsReq), .cfgOe(cfgOe), .targetResetN(targetResetN),
    .modeSel(modeSel), .spiOe(spiOe), .spiCsOut(spiCsOut), .busy(busy),
    .resultValid(resultValid), .resultCode(resultCode), .postPulse(postPulse)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic csAt(input int mode, input int p);
    case (mode)
      0:       return 1'b0;
      1:       return 1'b1;
      2:       return (p % 4) != 0;
      default: return p > 10;
    endcase
  endfunction

  // model of the poll loop from R4..R7
  task automatic model(input bit frc, input int dp, input int mode,
                       output int code, output int lat);
    int j = 0;
    code = -1; lat = -1;
    if (!frc && dp == 0) begin code = 1; lat = 0; return; end
    for (int p = 1; p <= PL + 1; p++) begin
      if (dp == 0 || p >= dp) begin code = 0; lat = (1 + S + p) * D; return; end
      if (p - 1 == PL || j == IL) begin code = 4; lat = (2 + S + p) * D; return; end
      j = csAt(mode, p) ? j + 1 : 0;
    end
  endtask

  task automatic runVec(input int idx);
    bit frc; int dp, mode, expCode, mCode, mLat, k, posts, spiBad, pIdx;
    logic pOe, pRst; logic [1:0] pMode; logic rstSeen, relSeen;
    frc = VEC[idx][15]; dp = int'(VEC[idx][14:5]); mode = int'(VEC[idx][4:3]);
    expCode = int'(VEC[idx][2:0]);
    model(frc, dp, mode, mCode, mLat);
    @(negedge clk);
    forceCfg = frc; targetDone = (dp == 0); flashCsIn = 1'b1; start = 1'b1;
    pOe = cfgOe; pRst = targetResetN; pMode = modeSel;
    posts = 0; spiBad = 0; rstSeen = 1'b0; relSeen = 1'b0;
    @(posedge clk); #1 start = 1'b0; k = 0;
    forever begin
      pIdx = (k + 1 + D - 1) / D - 1 - S;
      targetDone = (dp == 0) || (dp != NEVER && pIdx >= dp);
      flashCsIn  = (pIdx >= 1) ? csAt(mode, pIdx) : 1'b1;
      @(negedge clk);
      if (busy && spiOe != 3'b000) spiBad++;
      posts += int'(postPulse);
      if (k == 0) rstSeen = cfgOe && !targetResetN && modeSel == 2'b00;
      if (k == D) relSeen = cfgOe && targetResetN && modeSel == 2'b00;
      if (resultValid) break;
      if (k > 5000) begin
        check("watchdog", k, -1);
        return;
      end
      pOe = cfgOe; pRst = targetResetN; pMode = modeSel;
      @(posedge clk); #1 k++;
    end
    check($sformatf("R1/R6/R7 code vec%0d", idx), int'(resultCode), expCode);
    check($sformatf("R4/R5/R9 latency vec%0d", idx), k, mLat);
    check($sformatf("R6 post pulse vec%0d", idx), posts, (expCode == 0) ? 1 : 0);
    check($sformatf("R2 spi quiet vec%0d", idx), spiBad, 0);
    check($sformatf("R8 exit hi-z vec%0d", idx), int'(cfgOe), 0);
    if (expCode == 1)
      check("R1 target untouched", int'(pOe), 0);
    else if (expCode == 0) begin
      check($sformatf("R3 release pins vec%0d", idx), int'({pOe, pRst, pMode}), 4'b1100);
      check($sformatf("R3 reset tick vec%0d", idx), int'(rstSeen), 1);
      check($sformatf("R3 master release vec%0d", idx), int'(relSeen), 1);
    end else
      check($sformatf("R7 leave pins vec%0d", idx), int'({pOe, pRst, pMode}), 4'b1011);
    @(negedge clk);
    check($sformatf("R10 busy cleared vec%0d", idx), int'(busy), 0);
    check($sformatf("R8 local cs held vec%0d", idx), int'(spiCsOut), 1);
    targetDone = 1'b0;
  endtask

  initial begin
    #(2_000_000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 busy after reset", int'(busy), 0);
    check("R10 valid after reset", int'(resultValid), 0);
    check("R10 cfgOe after reset", int'(cfgOe), 0);
    check("R10 post after reset", int'(postPulse), 0);
    // R2 passthrough when idle
    spiOeReq = 3'b101;
    @(negedge clk);
    check("R2 idle passthrough", int'(spiOe), 5);
    for (int v = 0; v < NVEC; v++) runVec(v);
    // R2 enables restored after a run
    check("R2 restored after run", int'(spiOe), 5);
    // R8 chip-select hold released once request seen high
    spiCsReq = 1'b1;
    @(negedge clk);
    spiCsReq = 1'b0;
    @(negedge clk);
    check("R8 cs follows request", int'(spiCsOut), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule